// File: doc/BRIEF.md
# Shared-Port Attribute Register Interface

This block is the register front end of a text-mode attribute stage. Software reaches its registers through one byte-wide write port. An internal phase flag decides what each write means. A write in index phase selects a register. The write after it, in data phase, loads that register. A pulse on a separate status-read strobe returns the flag to index phase, so software can always find a known starting point.

Three kinds of register sit behind the port: sixteen 6-bit colour entries, an 8-bit mode register, and a 4-bit plane mask. Bit 3 of the mode register is driven out as `blink_sel`, which tells later logic whether attribute bit 7 means blink (1) or bright background (0).

Each cycle the block takes a 4-bit pixel code, ANDs it with the plane mask, looks the result up in the colour entries and registers the 6-bit result. Bit 5 of the stored index is the video-enable gate. While it is 0 the output is held at zero and the colour entries can be written. While it is 1 the colours are shown and the colour entries are locked.

The phase flag is a two-state machine:
- `PH_INDEX` goes to `PH_DATA` on a write (index load).
- `PH_DATA` goes to `PH_INDEX` on a write (data commit).
- Either state goes to `PH_INDEX` on a status read (realign).

Top module: `attr_port_ctrl`

## Requirements
- R1: After reset the phase is `PH_INDEX`, the stored index is 0, colour entry i holds the value i, the mode register holds 08h (`blink_sel`=1), the plane mask is Fh and `pix_out` is 0.
- R2: A write in index phase stores `wr_data[5:0]` as the index. `idx_rd` returns that value with bits 7:6 reading 0.
- R3: Writes alternate between the two phases: index, data, index, and so on. A data write goes to the register selected by index bits 4:0, and the index stays unchanged.
- R4: `status_rd` forces index phase at the next edge. A write presented in the same cycle is dropped completely.
- R5: Index values 00h–0Fh select colour entries. A data write stores `wr_data[5:0]` only while index bit 5 is 0, and is discarded while it is 1. `rd_data` returns {2'b00, entry}.
- R6: Index 10h selects the 8-bit mode register. `blink_sel` equals its bit 3 (1 = blink, 0 = bright background).
- R7: Index 12h selects the plane mask in `wr_data[3:0]`. `rd_data` returns {4'h0, mask}.
- R8: A data write to any other index changes no register but still returns the phase to index. `rd_data` reads 0 there.
- R9: `pix_out` is registered. One cycle after `pixel_in` is presented it equals entry[`pixel_in` & mask] if index bit 5 was 1, and 0 otherwise. It uses the register values held before that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the shared port |
| wr_data | input | 8 | Write byte (index or data, depending on phase) |
| status_rd | input | 1 | Status-port read strobe; realigns the phase |
| pixel_in | input | 4 | Pixel code to translate |
| idx_rd | output | 8 | Stored index readback |
| rd_data | output | 8 | Contents of the register the index selects |
| pix_out | output | 6 | Translated, gated pixel colour |
| blink_sel | output | 1 | Attribute bit 7 meaning: 1 blink, 0 intensity |

## Verification
Two pairs of functions can land in the same cycle. The first is a colour-entry or plane-mask commit alongside a pixel lookup. The registered output must still show the pre-write values, and the bench computes its expected pixel from its model before applying that cycle's write. The second is a status read arriving together with a write. A directed case leaves the phase in data and then applies both strobes at once. The check is that the index is unchanged and that the next write is taken as an index. Random traffic mixes both collisions through thousands of cycles.

// File: rtl/attr_port_pkg.sv
package attr_port_pkg;
    localparam int DATA_W     = 8;
    localparam int IDX_W      = 6;
    localparam int ADDR_W     = 5;
    localparam int PAL_N      = 16;
    localparam int PAL_W      = 6;
    localparam int PIX_W      = 4;
    localparam int SEL_W      = $clog2(PAL_N);
    localparam int VID_BIT    = 5;
    localparam int BLINK_BIT  = 3;
    localparam logic [ADDR_W-1:0] MODE_ADDR  = 5'h10;
    localparam logic [ADDR_W-1:0] PLANE_ADDR = 5'h12;
    localparam logic [DATA_W-1:0] MODE_RST   = 8'h08;

    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_t;
endpackage

// File: rtl/attr_phase_fsm.sv
module attr_phase_fsm
    import attr_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  logic   status_rd,
    output phase_t phase,
    output logic   idx_load,
    output logic   data_commit
);
    phase_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_INDEX;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        idx_load    = 1'b0;
        data_commit = 1'b0;
        unique case (state_q)
            PH_INDEX: begin
                if (status_rd) state_d = PH_INDEX;
                else if (wr_en) begin
                    idx_load = 1'b1;
                    state_d  = PH_DATA;
                end
            end
            PH_DATA: begin
                if (status_rd) state_d = PH_INDEX;
                else if (wr_en) begin
                    data_commit = 1'b1;
                    state_d     = PH_INDEX;
                end
            end
        endcase
    end

    assign phase = state_q;
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
    import attr_port_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   idx_load,
    input  logic                   data_commit,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [IDX_W-1:0]       idx_q,
    output logic [DATA_W-1:0]      mode_q,
    output logic [PIX_W-1:0]       plane_q,
    output logic [PAL_N*PAL_W-1:0] pal_flat,
    output logic [DATA_W-1:0]      rd_data
);
    logic [ADDR_W-1:0] addr;
    logic              pal_hit;
    logic [PAL_W-1:0]  pal_q [PAL_N];

    assign addr    = idx_q[ADDR_W-1:0];
    assign pal_hit = int'(addr) < PAL_N;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        idx_q <= '0;
        else if (idx_load) idx_q <= wr_data[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_RST;
            plane_q <= '1;
        end else if (data_commit) begin
            if (addr == MODE_ADDR)  mode_q  <= wr_data;
            if (addr == PLANE_ADDR) plane_q <= wr_data[PIX_W-1:0];
        end
    end

    for (genvar i = 0; i < PAL_N; i++) begin : g_pal
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pal_q[i] <= PAL_W'(i);
            else if (data_commit && !idx_q[VID_BIT] && pal_hit &&
                     addr[SEL_W-1:0] == SEL_W'(i))
                pal_q[i] <= wr_data[PAL_W-1:0];
        end
        assign pal_flat[i*PAL_W +: PAL_W] = pal_q[i];
    end

    always_comb begin
        rd_data = '0;
        if (pal_hit)                 rd_data = DATA_W'(pal_q[addr[SEL_W-1:0]]);
        else if (addr == MODE_ADDR)  rd_data = mode_q;
        else if (addr == PLANE_ADDR) rd_data = DATA_W'(plane_q);
    end
endmodule

// File: rtl/attr_pixel_path.sv
module attr_pixel_path
    import attr_port_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vid_on,
    input  logic [PIX_W-1:0]       pixel_in,
    input  logic [PIX_W-1:0]       plane_q,
    input  logic [PAL_N*PAL_W-1:0] pal_flat,
    output logic [PAL_W-1:0]       pix_out
);
    logic [PIX_W-1:0] masked;
    logic [PAL_W-1:0] colour;

    assign masked = pixel_in & plane_q;
    assign colour = pal_flat[int'(masked)*PAL_W +: PAL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pix_out <= '0;
        else if (vid_on) pix_out <= colour;
        else             pix_out <= '0;
    end
endmodule

// File: rtl/attr_port_ctrl.sv
module attr_port_ctrl
    import attr_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              status_rd,
    input  logic [PIX_W-1:0]  pixel_in,
    output logic [DATA_W-1:0] idx_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic [PAL_W-1:0]  pix_out,
    output logic              blink_sel
);
    phase_t                 phase;
    logic                   idx_load;
    logic                   data_commit;
    logic [IDX_W-1:0]       idx_q;
    logic [DATA_W-1:0]      mode_q;
    logic [PIX_W-1:0]       plane_q;
    logic [PAL_N*PAL_W-1:0] pal_flat;

    attr_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .status_rd(status_rd),
        .phase(phase), .idx_load(idx_load), .data_commit(data_commit)
    );

    attr_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .idx_load(idx_load), .data_commit(data_commit),
        .wr_data(wr_data), .idx_q(idx_q), .mode_q(mode_q), .plane_q(plane_q),
        .pal_flat(pal_flat), .rd_data(rd_data)
    );

    attr_pixel_path u_pix (
        .clk(clk), .rst_n(rst_n), .vid_on(idx_q[VID_BIT]), .pixel_in(pixel_in),
        .plane_q(plane_q), .pal_flat(pal_flat), .pix_out(pix_out)
    );

    assign idx_rd    = DATA_W'(idx_q);
    assign blink_sel = mode_q[BLINK_BIT];
endmodule

// File: rtl/attr_port_chk.sv
module attr_port_chk
    import attr_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              status_rd,
    input phase_t            phase,
    input logic [IDX_W-1:0]  idx_q,
    input logic [DATA_W-1:0] mode_q,
    input logic [PIX_W-1:0]  plane_q,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] idx_rd,
    input logic [PAL_W-1:0]  pix_out
);
    logic [ADDR_W-1:0] addr;
    logic              commit;
    logic              unimpl;

    assign addr   = idx_q[ADDR_W-1:0];
    assign commit = (phase == PH_DATA) && wr_en && !status_rd;
    assign unimpl = (int'(addr) >= PAL_N) && (addr != MODE_ADDR) && (addr != PLANE_ADDR);

    AST_IDX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) idx_rd[7:6] == 2'b00); // R2
    AST_INDEX_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_INDEX && wr_en && !status_rd) |=> phase == PH_DATA); // R3
    AST_DATA_TO_INDEX: assert property (@(posedge clk) disable iff (!rst_n) commit |=> (phase == PH_INDEX && $stable(idx_q))); // R3
    AST_STATUS_REALIGN: assert property (@(posedge clk) disable iff (!rst_n) status_rd |=> (phase == PH_INDEX && $stable(idx_q))); // R4
    AST_PAL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (commit && idx_q[VID_BIT] && int'(addr) < PAL_N) |=> $stable(rd_data)); // R5
    AST_UNIMP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (commit && unimpl) |=> ($stable(mode_q) && $stable(plane_q))); // R8
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !idx_q[VID_BIT] |=> pix_out == '0); // R9
endmodule

bind attr_port_ctrl attr_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .status_rd(status_rd), .phase(phase),
    .idx_q(idx_q), .mode_q(mode_q), .plane_q(plane_q), .rd_data(rd_data),
    .idx_rd(idx_rd), .pix_out(pix_out)
);

// File: tb/attr_port_ctrl_tb_top.sv
module attr_port_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       status_rd = 1'b0;
    logic [3:0] pixel_in = '0;
    logic [7:0] idx_rd;
    logic [7:0] rd_data;
    logic [5:0] pix_out;
    logic       blink_sel;

    int checks = 0;
    int failures = 0;

    logic       m_ph;
    logic [5:0] m_idx;
    logic [5:0] m_pal [16];
    logic [7:0] m_mode;
    logic [3:0] m_plane;

    always #4 clk = ~clk;

    attr_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .status_rd(status_rd), .pixel_in(pixel_in), .idx_rd(idx_rd),
        .rd_data(rd_data), .pix_out(pix_out), .blink_sel(blink_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_rd();
        if (m_idx[4:0] < 5'd16)  return int'(m_pal[m_idx[3:0]]);
        if (m_idx[4:0] == 5'h10) return int'(m_mode);
        if (m_idx[4:0] == 5'h12) return int'(m_plane);
        return 0;
    endfunction

    function automatic string rd_tag();
        if (m_idx[4:0] < 5'd16)  return "R5 colour entry readback";
        if (m_idx[4:0] == 5'h10) return "R6 mode readback";
        if (m_idx[4:0] == 5'h12) return "R7 plane mask readback";
        return "R8 unimplemented index reads zero";
    endfunction

    task automatic step(input logic w, input logic [7:0] d, input logic s, input logic [3:0] p);
        logic [5:0] exp_pix;
        wr_en = w; wr_data = d; status_rd = s; pixel_in = p;
        exp_pix = m_idx[5] ? m_pal[p & m_plane] : 6'd0;
        if (s) m_ph = 1'b0;
        else if (w) begin
            if (!m_ph) begin
                m_idx = d[5:0];
                m_ph  = 1'b1;
            end else begin
                if (m_idx[4:0] < 5'd16 && !m_idx[5]) m_pal[m_idx[3:0]] = d[5:0];
                else if (m_idx[4:0] == 5'h10)     m_mode = d;
                else if (m_idx[4:0] == 5'h12)     m_plane = d[3:0];
                m_ph = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; status_rd = 1'b0;
        chk("R9 pixel output", int'(pix_out), int'(exp_pix));
        chk("R2 index readback", int'(idx_rd), int'({2'b00, m_idx}));
        chk(rd_tag(), int'(rd_data), exp_rd());
        chk("R6 blink select", int'(blink_sel), int'(m_mode[3]));
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_ph = 1'b0; m_idx = '0; m_mode = 8'h08; m_plane = 4'hF;
        for (int i = 0; i < 16; i++) m_pal[i] = 6'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state straight after reset
        chk("R1 pix_out after reset", int'(pix_out), 0);
        chk("R1 index after reset", int'(idx_rd), 0);
        chk("R1 blink select after reset", int'(blink_sel), 1);
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 8'(i), 1'b0, 4'h0);
            chk("R1 colour entry reset value", int'(rd_data), i);
            step(1'b0, 8'h00, 1'b1, 4'h0);
        end
        step(1'b1, 8'h12, 1'b0, 4'h0);
        chk("R1 plane mask reset", int'(rd_data), 15);
        step(1'b0, 8'h00, 1'b1, 4'h0);
        // R3: index, data, then the next write is an index again
        step(1'b1, 8'hC3, 1'b0, 4'h0);
        chk("R2 upper index bits dropped", int'(idx_rd), 8'h03);
        step(1'b1, 8'h15, 1'b0, 4'h0);
        chk("R3 data write lands", int'(rd_data), 8'h15);
        step(1'b1, 8'h10, 1'b0, 4'h0);
        chk("R3 alternation back to index", int'(idx_rd), 8'h10);
        step(1'b1, 8'h00, 1'b0, 4'h0);
        chk("R6 intensity select", int'(blink_sel), 0);
        // R4: status read colliding with a data-phase write
        step(1'b1, 8'h05, 1'b0, 4'h0);
        step(1'b1, 8'h2A, 1'b1, 4'h0);
        chk("R4 collided write dropped", int'(rd_data), 5);
        step(1'b1, 8'h07, 1'b0, 4'h0);
        chk("R4 next write is index", int'(idx_rd), 7);
        step(1'b0, 8'h00, 1'b1, 4'h0);
        // R8: unimplemented index keeps the toggle
        step(1'b1, 8'h1F, 1'b0, 4'h0);
        step(1'b1, 8'hFF, 1'b0, 4'h0);
        step(1'b1, 8'h12, 1'b0, 4'h0);
        chk("R8 toggle after discarded write", int'(idx_rd), 8'h12);
        // R7 then R9: mask plus enable, colour entry locked while shown
        step(1'b1, 8'h05, 1'b0, 4'h0);
        step(1'b1, 8'h24, 1'b0, 4'h0);
        step(1'b1, 8'h3F, 1'b0, 4'h0);
        chk("R5 locked entry unchanged", int'(rd_data), 4);
        step(1'b0, 8'h00, 1'b0, 4'hF);
        chk("R9 masked lookup", int'(pix_out), 5);
        step(1'b0, 8'h00, 1'b1, 4'h0);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic       w;
            logic       s;
            logic [7:0] d;
            int         r;
            w = ($urandom % 2) == 0;
            s = ($urandom % 10) == 0;
            r = $urandom % 8;
            if (!m_ph) begin
                if (r < 4)       d = 8'($urandom % 16);
                else if (r == 4) d = 8'h10;
                else if (r == 5) d = 8'h12;
                else             d = 8'($urandom);
                if (($urandom % 2) == 0) d[5] = 1'b1;
            end else d = 8'($urandom);
            step(w, d, s, 4'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule